// File: doc/BRIEF.md
# Dual-Bank Offset Register File with Auto-Toggling Bank Pointer

This block holds the start and end offsets that a transfer address sequencer walks through for each frame. There are four offsets, each `OFS_W` bits wide: a start offset and an end offset in bank A, and another pair in bank B. Software reaches all four through one narrow byte bus. A single low-byte address and a single high-byte address serve the start pair, and another two serve the end pair. A hidden per-pair bank pointer decides whether an access lands in bank A or bank B.

When dual-bank operation is enabled, a write to a high byte flips that pair's pointer. The next access at the same addresses then reaches the other bank. The start pointer and the end pointer are independent. A mode register enables dual operation, reports both pointers, and can force either pointer back to bank A.

All four offsets are also driven in parallel to the sequencer. A one-cycle load strobe tells the sequencer to reload its live counter whenever the bank A start high byte is written. For this reason, software writes the bank A start offset last.

Top module: `ofs_bank_top`

## Requirements
- R1: After reset, all offsets are zero, both pointers select bank A, dual operation is off, the mode register reads 0x00, and `load_o` is low.
- R2: With dual operation on, a write to a start or end high byte flips that pair's pointer. A low-byte write never flips a pointer.
- R3: The start pointer and the end pointer are independent: an access to one pair never changes the other pair's pointer.
- R4: The mode register is at address 4. It reads bit0 = dual enable, bit1 = start pointer, bit2 = end pointer (1 = bank B), and bits 7..3 always read zero.
- R5: A mode write loads bit0 into dual enable. A 0 in bit1 forces the start pointer to bank A, and a 0 in bit2 forces the end pointer to bank A. A 1 in bit1 or bit2 leaves that pointer unchanged.
- R6: Address 0 is the start low byte, 1 the start high byte, 2 the end low byte and 3 the end high byte. The low byte holds offset bits 7..0, and bits 3..0 of the high byte hold offset bits 11..8. Each access reaches the bank chosen by its pair's pointer.
- R7: With dual operation on, reading a pair right after writing its bank A high byte returns bank B contents.
- R8: With dual operation off, no pointer ever flips, so every offset access reaches bank A.
- R9: Bits 7..4 of a high-byte read are zero, and the written values of those bits are discarded.
- R10: `load_o` is high for exactly the one cycle after each write to the bank A start high byte. It stays low after writes to bank B, to low bytes, or to the end pair.
- R11: The parallel outputs always show the current contents of all four offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| start_a_o | output | OFS_W | Bank A start offset |
| start_b_o | output | OFS_W | Bank B start offset |
| end_a_o | output | OFS_W | Bank A end offset |
| end_b_o | output | OFS_W | Bank B end offset |
| load_o | output | 1 | Counter reload strobe |

## Verification
The bench builds the block with its default 12-bit offsets on the 8-bit bus. With these values the high byte carries a real 4-bit field and a 4-bit unused upper nibble, so both the split across two bytes and the masking of the upper nibble can be exercised. The sequence alternates the pointers in dual mode and interleaves start and end accesses. It also clears and keeps pointers through mode writes, then switches dual mode off to show that accesses stay in bank A.

// File: rtl/ofs_bank_pkg.sv
package ofs_bank_pkg;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_ST_LO = 3'd0,
        REG_ST_HI = 3'd1,
        REG_EN_LO = 3'd2,
        REG_EN_HI = 3'd3,
        REG_MODE  = 3'd4
    } reg_addr_e;

    localparam int MB_DUAL  = 0;
    localparam int MB_STPTR = 1;
    localparam int MB_ENPTR = 2;

    localparam int CH_START = 0;
    localparam int CH_END   = 1;
    localparam int N_CH     = 2;

    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic rd_lo;
        logic rd_hi;
    } chan_sel_t;
endpackage

// File: rtl/ofs_bank_decode.sv
module ofs_bank_decode
    import ofs_bank_pkg::*;
(
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output chan_sel_t         sel_o [N_CH],
    output logic              mode_wr_o,
    output logic              mode_rd_o
);
    always_comb begin
        for (int c = 0; c < N_CH; c++) begin
            sel_o[c] = '0;
        end
        mode_wr_o = 1'b0;
        mode_rd_o = 1'b0;
        unique case (addr_i)
            REG_ST_LO: begin
                sel_o[CH_START].rd_lo = 1'b1;
                sel_o[CH_START].wr_lo = wr_en_i;
            end
            REG_ST_HI: begin
                sel_o[CH_START].rd_hi = 1'b1;
                sel_o[CH_START].wr_hi = wr_en_i;
            end
            REG_EN_LO: begin
                sel_o[CH_END].rd_lo = 1'b1;
                sel_o[CH_END].wr_lo = wr_en_i;
            end
            REG_EN_HI: begin
                sel_o[CH_END].rd_hi = 1'b1;
                sel_o[CH_END].wr_hi = wr_en_i;
            end
            REG_MODE: begin
                mode_rd_o = 1'b1;
                mode_wr_o = wr_en_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ofs_bank_pair.sv
module ofs_bank_pair
    import ofs_bank_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  chan_sel_t        sel_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic             dual_i,
    input  logic             clr_ptr_i,
    output logic             ptr_o,
    output logic [OFS_W-1:0] ofs_a_o,
    output logic [OFS_W-1:0] ofs_b_o,
    output logic [BUS_W-1:0] rd_o
);
    localparam int HI_W  = OFS_W - BUS_W;
    localparam int PAD_W = BUS_W - HI_W;

    typedef struct packed {
        logic             ptr;
        logic [OFS_W-1:0] a;
        logic [OFS_W-1:0] b;
    } pair_t;

    pair_t r_d, r_q;
    logic [OFS_W-1:0] cur, nxt;

    always_comb begin
        r_d = r_q;
        cur = r_q.ptr ? r_q.b : r_q.a;
        nxt = cur;
        if (sel_i.wr_lo) nxt[BUS_W-1:0]     = wdata_i;
        if (sel_i.wr_hi) nxt[OFS_W-1:BUS_W] = wdata_i[HI_W-1:0];
        if (sel_i.wr_lo || sel_i.wr_hi) begin
            if (r_q.ptr) r_d.b = nxt;
            else         r_d.a = nxt;
        end
        if (sel_i.wr_hi && dual_i) r_d.ptr = ~r_q.ptr;
        if (clr_ptr_i)             r_d.ptr = 1'b0;
        rd_o = '0;
        if (sel_i.rd_lo) rd_o = cur[BUS_W-1:0];
        if (sel_i.rd_hi) rd_o = {{PAD_W{1'b0}}, cur[OFS_W-1:BUS_W]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign ptr_o   = r_q.ptr;
    assign ofs_a_o = r_q.a;
    assign ofs_b_o = r_q.b;
endmodule

// File: rtl/ofs_bank_top.sv
module ofs_bank_top
    import ofs_bank_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [2:0]       addr_i,
    input  logic [7:0]       wdata_i,
    output logic [7:0]       rdata_o,
    output logic [OFS_W-1:0] start_a_o,
    output logic [OFS_W-1:0] start_b_o,
    output logic [OFS_W-1:0] end_a_o,
    output logic [OFS_W-1:0] end_b_o,
    output logic             load_o
);
    typedef struct packed {
        logic dual;
        logic load;
    } ctl_t;

    ctl_t             c_d, c_q;
    chan_sel_t        sel [N_CH];
    logic             mode_wr, mode_rd;
    logic [N_CH-1:0]  ptr;
    logic [N_CH-1:0]  clr;
    logic [OFS_W-1:0] ofs_a [N_CH];
    logic [OFS_W-1:0] ofs_b [N_CH];
    logic [BUS_W-1:0] ch_rd [N_CH];
    logic             st_ptr, en_ptr, dual_on;

    ofs_bank_decode u_dec (
        .wr_en_i  (wr_en_i),
        .addr_i   (addr_i),
        .sel_o    (sel),
        .mode_wr_o(mode_wr),
        .mode_rd_o(mode_rd)
    );

    assign clr[CH_START] = mode_wr && !wdata_i[MB_STPTR];
    assign clr[CH_END]   = mode_wr && !wdata_i[MB_ENPTR];

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        ofs_bank_pair #(.OFS_W(OFS_W)) u_pair (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .sel_i    (sel[c]),
            .wdata_i  (wdata_i),
            .dual_i   (c_q.dual),
            .clr_ptr_i(clr[c]),
            .ptr_o    (ptr[c]),
            .ofs_a_o  (ofs_a[c]),
            .ofs_b_o  (ofs_b[c]),
            .rd_o     (ch_rd[c])
        );
    end

    always_comb begin
        c_d      = c_q;
        c_d.load = sel[CH_START].wr_hi && !ptr[CH_START];
        if (mode_wr) c_d.dual = wdata_i[MB_DUAL];
        rdata_o = ch_rd[CH_START] | ch_rd[CH_END];
        if (mode_rd) begin
            rdata_o           = '0;
            rdata_o[MB_DUAL]  = c_q.dual;
            rdata_o[MB_STPTR] = ptr[CH_START];
            rdata_o[MB_ENPTR] = ptr[CH_END];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign st_ptr    = ptr[CH_START];
    assign en_ptr    = ptr[CH_END];
    assign dual_on   = c_q.dual;
    assign load_o    = c_q.load;
    assign start_a_o = ofs_a[CH_START];
    assign start_b_o = ofs_b[CH_START];
    assign end_a_o   = ofs_a[CH_END];
    assign end_b_o   = ofs_b[CH_END];
endmodule

// File: rtl/ofs_bank_chk.sv
module ofs_bank_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       wr_en_i,
    input logic [2:0] addr_i,
    input logic       keep_st,
    input logic       keep_en,
    input logic [3:0] rd_hi_nib,
    input logic       load_o,
    input logic       st_ptr,
    input logic       en_ptr,
    input logic       dual_on
);
    AST_TOGGLE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dual_on && wr_en_i && addr_i == 3'd1) |=> (st_ptr != $past(st_ptr))); // R2
    AST_LO_NO_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 3'd0) |=> $stable(st_ptr)); // R2
    AST_END_INDEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i != 3'd3 && addr_i != 3'd4) |=> $stable(en_ptr)); // R3
    AST_CLEAR_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 3'd4 && !keep_st) |=> !st_ptr); // R5
    AST_CLEAR_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 3'd4 && !keep_en) |=> !en_ptr); // R5
    AST_SINGLE_STAYS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dual_on && !st_ptr && !(wr_en_i && addr_i == 3'd4)) |=> !st_ptr); // R8
    AST_HI_NIBBLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == 3'd1 || addr_i == 3'd3) |-> (rd_hi_nib == 4'd0)); // R9
    AST_LOAD_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_o |-> $past(wr_en_i && addr_i == 3'd1 && !st_ptr)); // R10
endmodule

bind ofs_bank_top ofs_bank_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .keep_st  (wdata_i[1]),
    .keep_en  (wdata_i[2]),
    .rd_hi_nib(rdata_o[7:4]),
    .load_o   (load_o),
    .st_ptr   (st_ptr),
    .en_ptr   (en_ptr),
    .dual_on  (dual_on)
);

// File: tb/ofs_bank_top_bench.sv
`timescale 1ns/1ps
module ofs_bank_top_bench;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  addr_i = 3'd0;
    logic [7:0]  wdata_i = 8'd0;
    logic [7:0]  rdata_o;
    logic [11:0] start_a_o, start_b_o, end_a_o, end_b_o;
    logic        load_o;

    int checks = 0;
    int failures = 0;
    logic       mon_valid = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    bit         done = 1'b0;

    always #10 clk_i = ~clk_i;

    ofs_bank_top u_ofs_bank_top (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .start_a_o(start_a_o),
        .start_b_o(start_b_o), .end_a_o(end_a_o), .end_b_o(end_b_o), .load_o(load_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk_i) begin
        if (mon_valid && exp_q.size() > 0) begin
            chk(tag_q.pop_front(), {24'd0, rdata_o}, {24'd0, exp_q.pop_front()});
        end
    end

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk_i); #1;
        addr_i = a; mon_valid = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk_i); #1;
        mon_valid = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk_i); #1;
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(posedge clk_i); #1;
        wr_en_i = 1'b0;
    endtask

    task automatic chk_load(input logic exp, input string tag);
        chk(tag, {31'd0, load_o}, {31'd0, exp});
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk_i);
        #1 rst_ni = 1'b1;
        // R1 reset state
        chk("R1 load", {31'd0, load_o}, 0);
        chk("R1 start_a", {20'd0, start_a_o}, 0);
        chk("R1 end_b", {20'd0, end_b_o}, 0);
        rd(3'd4, 8'h00, "R1 mode");
        rd(3'd1, 8'h00, "R1 start hi");

        // single mode: R6, R9, R8, R10
        wr(3'd0, 8'h34);
        chk_load(1'b0, "R10 low byte");
        wr(3'd1, 8'hF5);
        chk_load(1'b1, "R10 A start hi");
        chk("R6 start_a", {20'd0, start_a_o}, 32'h534);
        rd(3'd1, 8'h05, "R9 hi nibble");
        chk_load(1'b0, "R10 one cycle");
        rd(3'd0, 8'h34, "R6 start lo");
        rd(3'd4, 8'h00, "R8 no toggle");
        chk("R8 start_b", {20'd0, start_b_o}, 0);
        wr(3'd2, 8'hCD);
        wr(3'd3, 8'h0A);
        chk_load(1'b0, "R10 end hi");
        chk("R6 end_a", {20'd0, end_a_o}, 32'hACD);
        rd(3'd4, 8'h00, "R8 end no toggle");

        // dual mode
        wr(3'd4, 8'h01);
        rd(3'd4, 8'h01, "R4 dual bit");
        wr(3'd0, 8'h11);
        rd(3'd4, 8'h01, "R2 lo no toggle");
        wr(3'd1, 8'h02);
        chk_load(1'b1, "R10 dual A hi");
        chk("R6 start_a dual", {20'd0, start_a_o}, 32'h211);
        rd(3'd4, 8'h03, "R2 start toggled");
        rd(3'd0, 8'h00, "R7 reads bank B");
        wr(3'd0, 8'h78);
        wr(3'd1, 8'h09);
        chk_load(1'b0, "R10 B hi");
        chk("R11 start_b", {20'd0, start_b_o}, 32'h978);
        rd(3'd4, 8'h01, "R2 back to A");
        wr(3'd3, 8'h0B);
        chk("R11 end_a", {20'd0, end_a_o}, 32'hBCD);
        rd(3'd4, 8'h05, "R3 end only");
        rd(3'd3, 8'h00, "R7 end bank B");
        wr(3'd1, 8'h02);
        rd(3'd4, 8'h07, "R3 both set");
        wr(3'd4, 8'h05);
        rd(3'd4, 8'h05, "R5 clear start keep end");
        wr(3'd4, 8'h03);
        rd(3'd4, 8'h01, "R5 clear end");
        wr(3'd4, 8'hFF);
        rd(3'd4, 8'h01, "R4 upper bits zero");
        wr(3'd0, 8'h55);
        chk("R2 lo write A", {20'd0, start_a_o}, 32'h255);
        wr(3'd4, 8'h00);
        rd(3'd4, 8'h00, "R8 dual off");
        chk("R11 end_b", {20'd0, end_b_o}, 0);

        repeat (2) @(posedge clk_i);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule